// File: doc/BRIEF.md
# Real-time wait state controller

This block lets external memory or slow peripherals stretch a bus strobe while it is in progress. It sits beside the bus sequencer and holds a two-bit control register written through a plain write port. Bit 0 turns on the active-low wait input and bit 1 turns on a wait clock output. When the wait input is on, the block samples the wait pin through a synchronizer and raises a stretch request toward the sequencer while a strobe phase is active. The sequencer answers by extending the current read, fetch or write strobe and holding its address and data.

The stretch request changes only on the boundary of an internal divide-by-two phase of the oscillator clock. So the strobe is always lengthened in whole units of two oscillator periods. The same phase drives the wait clock pin, so an external device that watches the wait clock knows when its wait level is sampled. Each enable bit also takes over the port pin that carries its signal, and the block reports this through one pin select output per feature.

Top module: `rtwait_ctrl`

## Requirements
- R1: After reset the control register reads 0, `stretch` is 0, `wclk_out` is 0, and both pin selects are 0.
- R2: When `cfg_we` is 1 at a clock edge, `cfg_wdata[1:0]` is stored. From the next cycle `cfg_rdata` shows the stored value. Bit 0 is the wait enable and bit 1 is the wait clock enable.
- R3: While bit 1 is set, `wclk_out` inverts on every clock edge, giving a square wave at half the clock rate. While bit 1 is clear, `wclk_out` is 0. An internal phase starts at 0 in reset and toggles on every edge from then on, and `wclk_out` equals that phase ANDed with bit 1.
- R4: `wait_pin_sel` equals control bit 0 and `wclk_pin_sel` equals control bit 1.
- R5: `wait_n_in` passes through two flops before it is used. The internal stretch flag is updated only at edges where the internal phase is 1, which are the falling edges of the wait clock. At such an edge it loads 1 exactly when bit 0 is set, `strobe_active` is 1, and the synchronized wait level is 0.
- R6: While bit 0 is clear, `stretch` is 0 whatever `wait_n_in` does.
- R7: While `strobe_active` is 0, `stretch` is 0. A stretch flag left over from an earlier strobe has no effect.
- R8: While `strobe_active` and bit 0 stay at 1, every run of `stretch` at 1 lasts an even number of clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 2 | Control write data: bit 0 is the wait enable, bit 1 is the wait clock enable |
| cfg_rdata | output | 2 | Current control register value |
| wait_n_in | input | 1 | Active-low wait request from the pin |
| strobe_active | input | 1 | From the sequencer: a read, fetch or write strobe phase is in progress |
| stretch | output | 1 | Request to the sequencer to extend the current strobe |
| wclk_out | output | 1 | Wait clock pin output |
| wait_pin_sel | output | 1 | The wait input has taken over its shared pin |
| wclk_pin_sel | output | 1 | The wait clock has taken over its shared pin |

## Verification
The hardest case to reach is a change on the wait pin that lands in each position relative to the divide-by-two phase. It must be checked together with a strobe that starts or ends while the stretch flag is still set. Random stimulus changes the wait level, the strobe and the control bits on single cycles, so every alignment against the phase comes up, and a cycle model in the bench tracks the expected request. Directed passes hold the strobe steady with the wait pin low to measure run lengths, and drive the wait pin with each enable bit in turn cleared.

// File: rtl/rtwait_ctrl.sv
module rtwait_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_wdata,
  output logic [1:0] cfg_rdata,
  input  logic       wait_n_in,
  input  logic       strobe_active,
  output logic       stretch,
  output logic       wclk_out,
  output logic       wait_pin_sel,
  output logic       wclk_pin_sel
);

  logic [1:0]             ctrl_q;
  logic                   phase_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hold_q;
  logic                   wait_low;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctrl_q <= 2'b00;
    else if (cfg_we) ctrl_q <= cfg_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;

  generate
    if (SYNC_STAGES > 1) begin : g_sync
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], wait_n_in};
    end else begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= wait_n_in;
    end
  endgenerate

  assign wait_low = ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       hold_q <= 1'b0;
    else if (phase_q) hold_q <= ctrl_q[0] & strobe_active & wait_low;

  assign stretch      = hold_q & strobe_active & ctrl_q[0];
  assign wclk_out     = phase_q & ctrl_q[1];
  assign cfg_rdata    = ctrl_q;
  assign wait_pin_sel = ctrl_q[0];
  assign wclk_pin_sel = ctrl_q[1];

  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata)); // R2

  AST_WCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1] && !cfg_we) |=> wclk_out != $past(wclk_out)); // R3

  AST_HOLD_ON_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_q |=> $stable(hold_q)); // R5

  AST_STRETCH_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |=> hold_q); // R8

endmodule

// File: tb/rtwait_ctrl_tb.sv
module rtwait_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_wdata = 0;
  logic wait_n_in = 1, strobe_active = 0;
  logic [1:0] cfg_rdata;
  logic stretch, wclk_out, wait_pin_sel, wclk_pin_sel;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtwait_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .wait_n_in(wait_n_in), .strobe_active(strobe_active),
    .stretch(stretch), .wclk_out(wclk_out), .wait_pin_sel(wait_pin_sel),
    .wclk_pin_sel(wclk_pin_sel));

  // reference model built from the requirements
  logic [1:0] m_ctrl;
  logic m_ph, m_s1, m_s2, m_hold;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_ctrl <= 0; m_ph <= 0; m_s1 <= 1; m_s2 <= 1; m_hold <= 0;
    end else begin
      if (cfg_we) m_ctrl <= cfg_wdata;
      m_ph <= !m_ph;
      m_s1 <= wait_n_in;
      m_s2 <= m_s1;
      if (m_ph) m_hold <= m_ctrl[0] && strobe_active && !m_s2;
    end

  function automatic logic exp_stretch();
    return m_hold && strobe_active && m_ctrl[0];
  endfunction
  function automatic logic exp_wclk();
    return m_ph && m_ctrl[1];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_cmp();
    chk(cfg_rdata == m_ctrl, "R2 cfg_rdata", cfg_rdata, m_ctrl);
    chk(wclk_out == exp_wclk(), "R3 wclk_out", wclk_out, exp_wclk());
    chk(wait_pin_sel == m_ctrl[0] && wclk_pin_sel == m_ctrl[1], "R4 pin_sel",
        {wclk_pin_sel, wait_pin_sel}, m_ctrl);
    chk(stretch == exp_stretch(), "R5 stretch", stretch, exp_stretch());
  endtask

  // one cycle: check at negedge, then drive new inputs
  task automatic cyc(input logic we, input logic [1:0] wd, input logic wn, input logic sa);
    @(negedge clk);
    model_cmp();
    cfg_we = we; cfg_wdata = wd; wait_n_in = wn; strobe_active = sa;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int run;
    logic prev;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 0 && stretch == 0 && wclk_out == 0 && !wait_pin_sel && !wclk_pin_sel,
        "R1 reset", {cfg_rdata, stretch, wclk_out}, 0);
    rst_n = 1;
    cyc(0, 0, 1, 0);
    // R3 disabled clock stays low
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 1, 0);
      chk(wclk_out == 0, "R3 wclk off", wclk_out, 0);
    end
    // R2 write and readback
    cyc(1, 2'b11, 1, 0);
    cyc(0, 2'b00, 1, 0);
    chk(cfg_rdata == 2'b11, "R2 readback", cfg_rdata, 3);
    chk(wait_pin_sel && wclk_pin_sel, "R4 takeover", {wclk_pin_sel, wait_pin_sel}, 3);
    prev = wclk_out;
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 1, 0);
      chk(wclk_out != prev, "R3 toggle", wclk_out, !prev);
      prev = wclk_out;
    end
    // R7 wait low outside strobe
    for (int i = 0; i < 8; i++) begin
      cyc(0, 0, 0, 0);
      chk(stretch == 0, "R7 no strobe", stretch, 0);
    end
    // R8 even run lengths with steady strobe
    for (int k = 0; k < 3; k++) begin
      cyc(0, 0, 1, 1);
      repeat (4) cyc(0, 0, 1, 1);
      run = 0;
      for (int i = 0; i < 6 + k; i++) begin
        cyc(0, 0, 0, 1);
        if (stretch) run++;
      end
      for (int i = 0; i < 10; i++) begin
        cyc(0, 0, 1, 1);
        if (stretch) run++;
      end
      chk(run > 0 && run % 2 == 0, "R8 run even", run, 6);
    end
    // R7 leftover flag cleared by strobe drop
    repeat (6) cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk(stretch == 0, "R7 strobe drop", stretch, 0);
    // R6 wait enable clear
    cyc(1, 2'b10, 0, 1);
    for (int i = 0; i < 10; i++) begin
      cyc(0, 0, 0, 1);
      chk(stretch == 0, "R6 disabled", stretch, 0);
    end
    chk(wait_pin_sel == 0 && wclk_pin_sel == 1, "R4 partial", {wclk_pin_sel, wait_pin_sel}, 2);
    // R5 random mix against the model
    for (int i = 0; i < 4000; i++) begin
      logic we;
      we = ($urandom % 40) == 0;
      cyc(we, we ? 2'($urandom % 4) : 2'b00, ($urandom % 3) != 0, ($urandom % 4) != 0);
    end
    cyc(0, 0, 1, 0);
    finish_run();
  end
endmodule